// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a watchdog that can also run as a periodic interval timer. Software reaches it through one 16-bit control word on a simple write/read bus. Every write must carry a fixed key in its upper byte. A write with the correct key updates the configuration. A write with any other upper byte changes nothing and asks the system for a reset. Reads always return a different fixed byte in the upper half, so a value read back cannot be written straight back as a valid key.

An internal counter advances on one of two clock enables: the fast sub-system enable or the slow auxiliary enable. Software cannot read the counter. One of four tap widths sets how many ticks make up one period. When a period ends, the interrupt flag is set. In supervision mode, the end of a period also sends a one-cycle reset request. In interval mode, the end of a period only raises the flag, and the flag reaches the interrupt request output only when the external enable is high. Two configuration bits are passed straight out to select the function and edge of an external reset/interrupt pin.

Top module: `kwd_top`

## Requirements
- R1: A read returns 0x69 in bits 15:8. Bits 7:0 hold the stored configuration: hold at bit 7, pin edge at bit 6, pin function at bit 5, mode at bit 4, clear at bit 3, clock select at bit 2 and interval code at bits 1:0. Bit 3 always reads 0.
- R2: A write takes effect only when bits 15:8 equal 0x5A. A write with any other upper byte leaves the configuration unchanged, and rstReq is high for exactly the one cycle after that write.
- R3: After reset, the configuration is 0x00, which selects supervision mode, the sub-system enable and the longest interval. rstReq, irqReq and irqFlag are all low.
- R4: While hold (bit 7) is 1, the counter does not advance, and no expiry takes place.
- R5: Clock select 0 makes the counter advance on subClkEn. Clock select 1 makes it advance on auxClkEn. The enable that is not selected has no effect.
- R6: Interval codes 00, 01, 10 and 11 end a period after 32768, 8192, 512 and 64 selected ticks, counted from a cleared counter.
- R7: In supervision mode (bit 4 = 0), an expiry sets irqFlag and makes rstReq high for one cycle. irqReq stays low.
- R8: In interval mode (bit 4 = 1), an expiry sets irqFlag and leaves rstReq low. irqReq equals irqFlag while intEnable is high, and it is low while intEnable is low.
- R9: irqFlag clears on flagClr in any mode, and on intAck in interval mode only. An expiry in the same cycle as a clear leaves the flag set.
- R10: A keyed write with bit 3 set clears the counter to zero. If an expiry would occur in the same cycle, the clear wins and there is no expiry.
- R11: pinNmiSel follows configuration bit 5, and pinEdgeFall follows configuration bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Write data: key in bits 15:8, configuration in bits 7:0 |
| rdData | output | 16 | Read value of the control word |
| subClkEn | input | 1 | Fast sub-system tick enable |
| auxClkEn | input | 1 | Slow auxiliary tick enable |
| intEnable | input | 1 | Interrupt enable for interval mode |
| intAck | input | 1 | Interrupt accepted; clears the flag in interval mode |
| flagClr | input | 1 | Software clear of the flag |
| rstReq | output | 1 | One-cycle system reset request |
| irqReq | output | 1 | Interval interrupt request |
| irqFlag | output | 1 | Expiry flag |
| pinNmiSel | output | 1 | Pin function select: 0 reset, 1 non-maskable interrupt |
| pinEdgeFall | output | 1 | Pin interrupt edge: 0 rising, 1 falling |

## Verification
The counter is hidden, so a wrong count can only be seen through the timing of irqFlag and rstReq. The bench therefore checks the cycle before and the cycle of each expected expiry. A counter that is off by one, or a tap that is wired wrong, then shows up within one period. A clear or hold that fails to act moves the next flag by a whole period, or by a fraction of one. A configuration register that takes a write with a bad key shows up at the next read, in the same cycle as the false reset request.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 16;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
  localparam logic [KEY_W-1:0] RD_KEY = 8'h69;
  localparam int N_TAPS = 4;
  localparam int SEL_W = $clog2(N_TAPS);

  // tick count per period is 2**tapBits(code)
  function automatic int tapBits(input int code);
    case (code)
      0: return 15;
      1: return 13;
      2: return 9;
      default: return 6;
    endcase
  endfunction

  localparam int CNT_W = tapBits(0);

  typedef struct packed {
    logic hold;
    logic edgeFall;
    logic pinNmi;
    logic intervalMode;
    logic clkAux;
    logic [SEL_W-1:0] tapSel;
  } cfg_t;

  typedef struct packed {
    logic cntClr;
    logic keyBad;
  } strobe_t;
endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [DATA_W-1:0] rdData
);
  logic keyOk;

  assign keyOk = wrEn && (wrData[DATA_W-1 -: KEY_W] == WR_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (keyOk) cfg <= {wrData[7:4], wrData[2:0]};
  end

  always_comb begin
    stb.cntClr = keyOk && wrData[3];
    stb.keyBad = wrEn && !keyOk;
  end

  assign rdData = {RD_KEY, cfg.hold, cfg.edgeFall, cfg.pinNmi, cfg.intervalMode,
                   1'b0, cfg.clkAux, cfg.tapSel};
endmodule

// File: rtl/kwd_dp.sv
module kwd_dp
  import kwd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t stb,
  input  logic    subClkEn,
  input  logic    auxClkEn,
  input  logic    intAck,
  input  logic    flagClr,
  output logic    irqFlag,
  output logic    rstReq
);
  logic [CNT_W-1:0]  cnt;
  logic [N_TAPS-1:0] tapHit;
  logic tick, expire;

  assign tick = !cfg.hold && (cfg.clkAux ? auxClkEn : subClkEn);

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int TB = tapBits(i);
    assign tapHit[i] = &cnt[TB-1:0];
  end

  assign expire = tick && tapHit[cfg.tapSel] && !stb.cntClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (stb.cntClr) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlag <= 1'b0;
    else if (expire) irqFlag <= 1'b1;
    else if (flagClr || (intAck && cfg.intervalMode)) irqFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else rstReq <= stb.keyBad || (expire && !cfg.intervalMode);
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              subClkEn,
  input  logic              auxClkEn,
  input  logic              intEnable,
  input  logic              intAck,
  input  logic              flagClr,
  output logic              rstReq,
  output logic              irqReq,
  output logic              irqFlag,
  output logic              pinNmiSel,
  output logic              pinEdgeFall
);
  cfg_t    cfg;
  strobe_t stb;

  kwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfg(cfg), .stb(stb), .rdData(rdData)
  );

  kwd_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .subClkEn(subClkEn), .auxClkEn(auxClkEn), .intAck(intAck), .flagClr(flagClr),
    .irqFlag(irqFlag), .rstReq(rstReq)
  );

  assign irqReq      = irqFlag && intEnable && cfg.intervalMode;
  assign pinNmiSel   = cfg.pinNmi;
  assign pinEdgeFall = cfg.edgeFall;
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        intEnable,
  input logic        rstReq,
  input logic        irqReq,
  input logic        irqFlag
);
  // R1
  always_comb begin
    if (rstN) rd_key_chk: assert (rdData[15:8] == 8'h69 && !rdData[3]);
  end

  // R2
  bad_key_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != 8'h5A) |=> rstReq);

  // R2
  bad_key_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] != 8'h5A) |=> $stable(rdData));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqFlag && intEnable && rdData[4]));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[15:8] == 8'h5A && wrData[3] && !irqFlag) |=> !irqFlag);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !irqFlag) |=> !irqFlag);
endmodule

bind kwd_top kwd_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .intEnable(intEnable), .rstReq(rstReq), .irqReq(irqReq), .irqFlag(irqFlag)
);

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {write word, expected read word, expected rstReq}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h5A80, 16'h6980, 1'b0},
    {16'h5A08, 16'h6900, 1'b0},
    {16'h1234, 16'h6900, 1'b1},
    {16'h5A7F, 16'h6977, 1'b0},
    {16'h5AFF, 16'h69F7, 1'b0},
    {16'h0000, 16'h69F7, 1'b1},
    {16'h5A5A, 16'h6952, 1'b0},
    {16'h5A00, 16'h6900, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, subClkEn = 1'b0, auxClkEn = 1'b0;
  logic intEnable = 1'b0, intAck = 1'b0, flagClr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic rstReq, irqReq, irqFlag, pinNmiSel, pinEdgeFall;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwd_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .subClkEn(subClkEn), .auxClkEn(auxClkEn), .intEnable(intEnable),
    .intAck(intAck), .flagClr(flagClr), .rstReq(rstReq), .irqReq(irqReq),
    .irqFlag(irqFlag), .pinNmiSel(pinNmiSel), .pinEdgeFall(pinEdgeFall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic withTick);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; auxClkEn = withTick;
    @(negedge clk);
    wrEn = 1'b0; auxClkEn = 1'b0;
  endtask

  task automatic aux(input int n);
    @(negedge clk);
    auxClkEn = 1'b1;
    repeat (n) @(negedge clk);
    auxClkEn = 1'b0;
  endtask

  task automatic sub(input int n);
    @(negedge clk);
    subClkEn = 1'b1;
    repeat (n) @(negedge clk);
    subClkEn = 1'b0;
  endtask

  task automatic ack(input logic alsoTick);
    @(negedge clk);
    intAck = 1'b1; auxClkEn = alsoTick;
    @(negedge clk);
    intAck = 1'b0; auxClkEn = 1'b0;
  endtask

  task automatic swClr();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 rd", rdData, 16'h6900);
    chk("R3 flags", {rstReq, irqReq, irqFlag}, 3'b000);

    // R1 R2 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][32:17], 1'b0);
      chk("R1 R2 rd", rdData, VEC[i][16:1]);
      chk("R2 rstReq", rstReq, VEC[i][0]);
      chk("R11 pins", {pinEdgeFall, pinNmiSel}, {VEC[i][7], VEC[i][6]});
    end

    // R5 R6 R8: interval, aux clock, /64, counter cleared
    wr(16'h5A1F, 1'b0);
    sub(100);
    chk("R5 sub ignored", irqFlag, 1'b0);
    aux(63);
    chk("R6 before 64", irqFlag, 1'b0);
    aux(1);
    chk("R8 flag set", irqFlag, 1'b1);
    chk("R8 no rst", rstReq, 1'b0);
    chk("R8 irq gated off", irqReq, 1'b0);
    intEnable = 1'b1;
    #1;
    chk("R8 irq on", irqReq, 1'b1);
    ack(1'b0);
    chk("R9 ack clears", {irqFlag, irqReq}, 2'b00);
    aux(63);
    chk("R9 pre", irqFlag, 1'b0);
    ack(1'b1);
    chk("R9 set wins", irqFlag, 1'b1);

    // R10 clear beats expiry
    aux(63);
    ack(1'b0);
    chk("R10 flag cleared", irqFlag, 1'b0);
    wr(16'h5A1F, 1'b1);
    chk("R10 no expiry", irqFlag, 1'b0);
    aux(63);
    chk("R10 restart", irqFlag, 1'b0);
    aux(1);
    chk("R10 period", irqFlag, 1'b1);
    ack(1'b0);

    // R4 hold
    wr(16'h5A9F, 1'b0);
    aux(100);
    chk("R4 held", irqFlag, 1'b0);
    wr(16'h5A17, 1'b0);
    aux(63);
    chk("R4 resume", irqFlag, 1'b0);
    aux(1);
    chk("R4 period", irqFlag, 1'b1);
    ack(1'b0);

    // R7 supervision
    wr(16'h5A0F, 1'b0);
    aux(63);
    chk("R7 pre", {rstReq, irqFlag}, 2'b00);
    aux(1);
    chk("R7 expiry", {rstReq, irqFlag, irqReq}, 3'b110);
    @(negedge clk);
    chk("R7 pulse", rstReq, 1'b0);
    ack(1'b0);
    chk("R9 ack ignored", irqFlag, 1'b1);
    swClr();
    chk("R9 sw clear", irqFlag, 1'b0);

    // R6 remaining codes
    wr(16'h5A0E, 1'b0);
    aux(511);
    chk("R6 512 pre", rstReq, 1'b0);
    aux(1);
    chk("R6 512", rstReq, 1'b1);
    swClr();
    wr(16'h5A0D, 1'b0);
    aux(8191);
    chk("R6 8192 pre", rstReq, 1'b0);
    aux(1);
    chk("R6 8192", rstReq, 1'b1);
    swClr();
    wr(16'h5A0C, 1'b0);
    aux(32767);
    chk("R6 32768 pre", irqFlag, 1'b0);
    aux(1);
    chk("R6 32768", {rstReq, irqFlag}, 2'b11);

    finishRun();
  end
endmodule